// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an external asynchronous static RAM of 8192 words of 8 bits. The user side takes one request at a time over a valid/ready handshake. A request carries a direction flag, an address and, for writes, a data byte. Completion is signalled by a one-cycle response pulse, which carries the read byte for reads.

The memory side drives a low-active and a high-active chip select, a write strobe, an output-enable strobe and the address. The data bus is split into an outgoing byte with its tri-state enable and an incoming byte; the pad joins them. All memory timing comes from counting clock cycles. Every nanosecond figure is a parameter, and each is turned into a cycle count by rounding up against the clock-period parameter.

Back-pressure rules:
- `req_ready` is high only while no access is in progress.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- A `req_valid` raised while `req_ready` is low is not taken and has no effect on the memory.
- The response cannot be stalled: `rsp_valid` lasts exactly one cycle and must be consumed when it appears.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever idle, both chip selects are inactive (`mem_ce_n`=1, `mem_ce`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request is accepted only on an edge with `req_valid`=1 and `req_ready`=1. `req_ready` stays low from acceptance until the response cycle. A request presented while busy changes neither the memory contents nor the timing of the access in progress.
- R3: The two chip selects always show opposite levels. They are active for the whole of each access and inactive between accesses.
- R4: The write timing is built from the following counts, where ceil(t) is the rounded-up cycle count of time t:
  - A = max(1, ceil(tAS)) is the number of selected cycles with the write strobe high before it falls.
  - D = max(ceil(tWZ), ceil(tOHZ) − A).
  - The write strobe is low for exactly L = max(ceil(tWP), D + ceil(tDW), max(ceil(tCW), ceil(tAW)) − A) cycles.
  - Selection then continues for Rc = max(1, ceil(tWR), ceil(tWC) − A − L) cycles.
  - The address is the same across the whole access.
- R5: `mem_oe_n` is high throughout every write.
- R6: `mem_dq_oe` is high only while the write strobe is low and the memory is selected. It starts only once the strobe has been low for more than D cycles. It is then held to the end of the strobe, giving at least ceil(tDW) driven cycles, and the byte written is the request's data.
- R7: Every access keeps the memory selected for at least ceil(tWC) cycles for a write and ceil(tRC) cycles for a read.
- R8: A read holds `mem_we_n`=1 and `mem_oe_n`=0 for max(ceil(tAA), ceil(tOE), ceil(tRC)) cycles. It registers `mem_dq_in` on the last of them, and `rsp_rdata` then shows that byte.
- R9: `rsp_valid` is a single-cycle pulse. It appears A+L+Rc+1 cycles after a write is accepted and R+1 cycles after a read is accepted, where R is the read window.
- R10: A nonzero time rounds up to at least one cycle, and a time that is an exact multiple of the period rounds to exactly that many cycles.
- R11: The controller never drives the bus while `mem_oe_n` is low, nor within ceil(tOHZ) cycles after `mem_oe_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Word address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Byte returned by the last read |
| mem_addr | output | ADDR_W (13) | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W (8) | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W (8) | Byte read from the memory bus |

## Verification
The bench builds the controller with `ADDR_W`=6 and `CLK_PERIOD_NS`=50. This shrinks the space to 64 words, so every address can be written, read back, rewritten and read again back to back, which exercises the read-to-write bus turnaround at every location. At 50 ns the figures round to distinct small counts: a 2-cycle setup, a 4-cycle strobe whose first 2 cycles are undriven, a 4-cycle recovery and a 10-cycle read window. A shortened or lengthened phase therefore shows up in the cycle counts the bench measures. The bench's memory model returns the inverted byte until the access time has elapsed, so a read window that is too short returns the wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WPULSE,
    PH_WREC,
    PH_READ
  } phase_e;

  // round a time up to whole clock periods
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    if (ns == 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned LEN_AS   = 5,
  parameter int unsigned LEN_WLOW = 8,
  parameter int unsigned LEN_WREC = 12,
  parameter int unsigned LEN_RD   = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_done,
  output phase_e           phase,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             rsp_valid
);

  localparam logic [CNT_W-1:0] LD_AS   = CNT_W'(LEN_AS - 1);
  localparam logic [CNT_W-1:0] LD_WLOW = CNT_W'(LEN_WLOW - 1);
  localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(LEN_WREC - 1);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(LEN_RD - 1);

  phase_e nxt;
  logic   finish;

  assign accept = (phase == PH_IDLE) && req_valid;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    finish   = 1'b0;
    unique case (phase)
      PH_IDLE: if (req_valid) begin
        nxt      = req_write ? PH_WSETUP : PH_READ;
        load     = 1'b1;
        load_val = req_write ? LD_AS : LD_RD;
      end
      PH_WSETUP: if (timer_done) begin
        nxt      = PH_WPULSE;
        load     = 1'b1;
        load_val = LD_WLOW;
      end
      PH_WPULSE: if (timer_done) begin
        nxt      = PH_WREC;
        load     = 1'b1;
        load_val = LD_WREC;
      end
      PH_WREC: if (timer_done) begin
        nxt    = PH_IDLE;
        finish = 1'b1;
      end
      PH_READ: if (timer_done) begin
        nxt     = PH_IDLE;
        finish  = 1'b1;
        capture = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      phase     <= nxt;
      rsp_valid <= finish;
    end
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_AS_NS       = 100,
  parameter int unsigned T_WP_NS       = 150,
  parameter int unsigned T_WR_NS       = 50,
  parameter int unsigned T_DW_NS       = 100,
  parameter int unsigned T_CW_NS       = 250,
  parameter int unsigned T_AW_NS       = 250,
  parameter int unsigned T_WC_NS       = 500,
  parameter int unsigned T_RC_NS       = 500,
  parameter int unsigned T_AA_NS       = 500,
  parameter int unsigned T_OE_NS       = 200,
  parameter int unsigned T_OHZ_NS      = 40,
  parameter int unsigned T_WZ_NS       = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned C_AS   = max2(1, ns_to_cyc(T_AS_NS, CLK_PERIOD_NS));
  localparam int unsigned C_WP   = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WR   = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
  localparam int unsigned C_DW   = max2(1, ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int unsigned C_CW   = ns_to_cyc(T_CW_NS, CLK_PERIOD_NS);
  localparam int unsigned C_AW   = ns_to_cyc(T_AW_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned C_AA   = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
  localparam int unsigned C_OE   = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_OHZ  = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WZ   = ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS);

  localparam int unsigned C_DRV  = max2(C_WZ, sat_sub(C_OHZ, C_AS));
  localparam int unsigned C_WLOW = max2(max2(max2(C_WP, 1), C_DRV + C_DW),
                                        sat_sub(max2(C_CW, C_AW), C_AS));
  localparam int unsigned C_WREC = max2(max2(C_WR, 1), sat_sub(C_WC, C_AS + C_WLOW));
  localparam int unsigned C_RD   = max2(max2(C_AA, C_OE), max2(C_RC, 1));
  localparam int unsigned C_MAX  = max2(max2(C_AS, C_WLOW), max2(C_WREC, C_RD));
  localparam int unsigned CNT_W  = $clog2(C_MAX + 1);

  // strobe-low cycles still to go when the drivers may switch on
  localparam logic [CNT_W-1:0] DRV_LIMIT = CNT_W'(C_WLOW - 1 - C_DRV);

  phase_e           phase;
  logic             load, accept, capture, timer_done;
  logic [CNT_W-1:0] load_val, cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .done     (timer_done)
  );

  sram_phase_fsm #(
    .CNT_W    (CNT_W),
    .LEN_AS   (C_AS),
    .LEN_WLOW (C_WLOW),
    .LEN_WREC (C_WREC),
    .LEN_RD   (C_RD)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .timer_done (timer_done),
    .phase      (phase),
    .load       (load),
    .load_val   (load_val),
    .accept     (accept),
    .capture    (capture),
    .rsp_valid  (rsp_valid)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata_q)
  );

  assign req_ready  = (phase == PH_IDLE);
  assign mem_ce_n   = (phase == PH_IDLE);
  assign mem_ce     = (phase != PH_IDLE);
  assign mem_we_n   = (phase != PH_WPULSE);
  assign mem_oe_n   = (phase != PH_READ);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (phase == PH_WPULSE) && (cnt <= DRV_LIMIT);
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_WC_NS       = 500,
  parameter int unsigned T_RC_NS       = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int unsigned MIN_SEL = (ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) < ns_to_cyc(T_RC_NS, CLK_PERIOD_NS))
                                    ? ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) : ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);

  int unsigned sel_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_cnt <= 0;
    else if (!mem_ce_n) sel_cnt <= sel_cnt + 1;
    else               sel_cnt <= 0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !rsp_valid |-> mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe);

  p_busy_by_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  p_select_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n != mem_ce);

  p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n && $past(!mem_ce_n) |-> $stable(mem_addr));

  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n && !mem_ce_n);

  p_drive_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe && $past(mem_dq_oe) |-> $stable(mem_dq_out));

  p_min_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> sel_cnt >= MIN_SEL);

  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ack_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready && mem_ce_n);

  p_no_drive_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WC_NS       (T_WC_NS),
  .T_RC_NS       (T_RC_NS)
) u_sram_ctrl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_ce     (mem_ce),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int AW     = 6;
  localparam int DW     = 8;
  localparam int P      = 50;
  localparam int WORDS  = 1 << AW;

  function automatic int cyc(input int ns);
    return (ns + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_AS   = mx(1, cyc(100));
  localparam int E_DW   = cyc(100);
  localparam int E_OHZ  = cyc(40);
  localparam int E_WZ   = cyc(60);
  localparam int E_WC   = cyc(500);
  localparam int E_AA   = cyc(500);
  localparam int E_D    = mx(E_WZ, E_OHZ - E_AS);
  localparam int E_WLOW = mx(mx(cyc(150), E_D + E_DW), mx(cyc(250), cyc(250)) - E_AS);
  localparam int E_WREC = mx(mx(1, cyc(50)), E_WC - E_AS - E_WLOW);
  localparam int E_RD   = mx(mx(cyc(500), cyc(200)), cyc(500));
  localparam int E_WLAT = E_AS + E_WLOW + E_WREC + 1;
  localparam int E_RLAT = E_RD + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  logic [DW-1:0] arr [0:WORDS-1];
  logic          rd_ok = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  assign mem_dq_in = rd_ok ? arr[mem_addr] : ~arr[mem_addr];

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(P)
  ) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model and timing monitor
  int sel_cnt = 0, we_cnt = 0, drv_cnt = 0, rec_cnt = 0, rd_age = 0, since_oe = 100;
  int viol_pair = 0, viol_oe = 0, viol_drive = 0, viol_turn = 0;
  logic prev_sel = 1'b0, prev_we_n = 1'b1, wrote = 1'b0;
  logic [AW-1:0] fall_addr = '0;
  logic [DW-1:0] last_dq = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic sel = !mem_ce_n && mem_ce;
      if (mem_ce_n == mem_ce) viol_pair++;
      if (!mem_we_n && !mem_oe_n) viol_oe++;
      if (mem_dq_oe && (mem_we_n || !sel)) viol_drive++;
      if (!mem_oe_n) since_oe = 0; else if (since_oe < 100) since_oe++;
      if (mem_dq_oe && since_oe <= E_OHZ) viol_turn++;
      if (sel) sel_cnt++;
      if (sel && !mem_we_n) begin
        if (prev_we_n) begin
          chk(sel_cnt - 1 == E_AS, "R4 setup cycles", sel_cnt - 1, E_AS);
          fall_addr = mem_addr;
          we_cnt = 0;
          drv_cnt = 0;
        end
        we_cnt++;
        if (mem_dq_oe) begin drv_cnt++; last_dq = mem_dq_out; end
        else drv_cnt = 0;
        if (mem_dq_oe && we_cnt <= E_D) viol_turn++;
      end
      if (sel && mem_we_n && !prev_we_n) begin
        chk(we_cnt == E_WLOW, "R4 strobe low cycles", we_cnt, E_WLOW);
        chk(drv_cnt >= E_DW, "R6 driven cycles before strobe end", drv_cnt, E_DW);
        chk(fall_addr == mem_addr, "R4 address held", int'(mem_addr), int'(fall_addr));
        arr[mem_addr] = last_dq;
        rec_cnt = 0;
        wrote = 1'b1;
      end
      if (sel && mem_we_n && wrote) rec_cnt++;
      if (!sel && prev_sel) begin
        if (wrote) begin
          chk(rec_cnt == E_WREC, "R4 recovery cycles", rec_cnt, E_WREC);
          chk(sel_cnt >= E_WC, "R7 write select cycles", sel_cnt, E_WC);
        end else begin
          chk(sel_cnt >= E_RD, "R7 read select cycles", sel_cnt, E_RD);
        end
        sel_cnt = 0;
        wrote = 1'b0;
      end
      if (sel && mem_we_n && !mem_oe_n) rd_age++; else rd_age = 0;
      rd_ok = (rd_age >= E_AA);
      prev_sel = sel;
      prev_we_n = sel ? mem_we_n : 1'b1;
    end
  end

  // one request; poke=1 presents a second request while busy
  task automatic do_req(input bit wr, input int a, input int d, input bit poke, input int pa, input int pd);
    int lat;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(pa); req_wdata = DW'(pd);
      end else begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    chk(lat == (wr ? E_WLAT : E_RLAT), wr ? "R9 R10 write latency" : "R9 R10 read latency",
        lat, wr ? E_WLAT : E_RLAT);
    if (!wr) chk(rsp_rdata == DW'(d), "R8 read data", int'(rsp_rdata), d);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 single-cycle response", int'(rsp_valid), 0);
  endtask

  function automatic int pat1(input int a);
    return (a * 37 + 5) & 8'hFF;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(mem_ce_n == 1'b1 && mem_ce == 1'b0, "R1 deselected", int'({mem_ce_n, mem_ce}), 2);
    chk(mem_we_n && mem_oe_n, "R1 strobes high", int'({mem_we_n, mem_oe_n}), 3);
    chk(!mem_dq_oe && !rsp_valid, "R1 no drive, no response", int'({mem_dq_oe, rsp_valid}), 0);

    for (int a = 0; a < WORDS; a++) do_req(1'b1, a, pat1(a), 1'b0, 0, 0);
    for (int a = 0; a < WORDS; a++) do_req(1'b0, a, pat1(a), 1'b0, 0, 0);
    // back-to-back write then read at every word: bus turnaround (R11)
    for (int a = 0; a < WORDS; a++) begin
      do_req(1'b1, a, pat1(a) ^ 8'hFF, 1'b0, 0, 0);
      do_req(1'b0, a, pat1(a) ^ 8'hFF, 1'b0, 0, 0);
    end
    // R2: a request raised while busy is not taken
    do_req(1'b1, 3, 8'hC3, 1'b1, 9, 8'h11);
    @(negedge clk);
    chk(mem_ce_n == 1'b1, "R2 no access started from busy request", int'(mem_ce_n), 1);
    do_req(1'b0, 9, pat1(9) ^ 8'hFF, 1'b0, 0, 0);
    do_req(1'b0, 3, 8'hC3, 1'b0, 0, 0);
    // R1 idle after traffic
    @(negedge clk);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle after traffic", 0, 0);

    chk(viol_pair == 0, "R3 chip selects opposite", viol_pair, 0);
    chk(viol_oe == 0, "R5 output enable high in write", viol_oe, 0);
    chk(viol_drive == 0, "R6 drive only during strobe", viol_drive, 0);
    chk(viol_turn == 0, "R11 turnaround windows", viol_turn, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule